// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block rounds an unsigned binary mantissa that arrives with two extra low-order bits and a separate sticky bit. The two extra bits are the guard bit (bit 1 of the input) and the round bit (bit 0). The block drops them by shifting right by two. It then decides, from the selected rounding mode and the sign of the value, whether to add one to what remains. It also reports whether the increment happened and whether any precision was lost.

The adder keeps its carry-out as an extra top bit. A mantissa of all ones can therefore round up to the next power of two. Renormalising that result is left to the caller, as are exponent adjustment, packing into a storage format and any exception trapping. The result is registered, so outputs appear one clock after the inputs are sampled.

Top module: `mant_rounder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs are cleared to zero on that edge.
- R2: The outputs show the rounding of the inputs sampled at the previous rising edge. They do not change between edges.
- R3: When guard, round and sticky are all zero, `res_mant` equals the input shifted right by two, and both `res_up` and `res_inexact` are 0, in every mode.
- R4: `res_inexact` is 1 exactly when at least one of guard, round or sticky is 1, whatever the mode and sign.
- R5: With `rnd_mode` = 2'b00 (nearest), the block increments only when guard is 1 and at least one of the following holds: round is 1, sticky is 1, or bit 2 of the input (the low bit after the shift) is 1. An exact tie therefore rounds to even.
- R6: With `rnd_mode` = 2'b01 (toward zero), the block never increments.
- R7: With `rnd_mode` = 2'b10 (toward plus infinity), the block increments on inexact inputs only when `val_neg` is 0. With 2'b11 (toward minus infinity), it increments on inexact inputs only when `val_neg` is 1.
- R8: The increment adds one at the low bit of the shifted mantissa and carries through its full width into the extra top bit of `res_mant`. An all-ones input that rounds up gives only the top bit set.
- R9: `res_up` is 1 exactly when `res_mant` equals the shifted input plus one. Otherwise `res_mant` equals the shifted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_mant | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| raw_sticky | input | 1 | OR of all bits below the round bit |
| val_neg | input | 1 | Sign of the value, 1 for negative |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| res_mant | output | MANT_W-1 | Shifted mantissa after optional increment, carry-out in top bit |
| res_up | output | 1 | Increment was applied |
| res_inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
Several properties are checked on every clock cycle:
- an increment implies an inexact result;
- toward-zero never increments;
- the directed modes never increment for the wrong sign;
- nearest never increments with a clear guard bit;
- the inexact flag tracks the discarded bits;
- the result is always the shifted input or that value plus one, as `res_up` says.

Only the bench's scenarios can show the rest:
- that ties go to the even neighbour and not up;
- that the directed modes do increment when they should;
- that a full carry reaches the extra top bit;
- the exact reset and latency timing.

// File: rtl/rnd_pkg.sv
// Package: shared rounding-mode encoding for the mantissa rounder.
// Assumes a 2-bit selector; all four codes are defined.
package rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POSINF  = 2'b10,
        RM_NEGINF  = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
// Module: rnd_decide
// Decides whether the kept mantissa must be bumped by one and whether
// any precision was lost. Assumes guard/round are the two dropped bits,
// sticky summarises everything below them, keep_lsb is the low kept bit.
module rnd_decide
    import rnd_pkg::*;
(
    input  logic      guard_bit,
    input  logic      round_bit,
    input  logic      sticky_bit,
    input  logic      keep_lsb,
    input  logic      neg,
    input  rnd_mode_e mode,
    output logic      bump,
    output logic      inexact
);
    logic lost;

    // Purpose: flag any discarded nonzero bit.
    always_comb begin
        lost    = guard_bit | round_bit | sticky_bit;
        inexact = lost;
    end

    // Purpose: per-mode increment decision.
    always_comb begin
        bump = 1'b0;
        if (lost) begin
            case (mode)
                RM_ZERO:   bump = 1'b0;
                RM_POSINF: bump = ~neg;
                RM_NEGINF: bump = neg;
                default:   bump = guard_bit & (round_bit | sticky_bit | keep_lsb);
            endcase
        end
    end

    // Immediate checks beside the decision logic.
    always_comb begin
        if (bump) begin
            AST_BUMP_NEEDS_LOSS: assert (lost); // R3
        end
        if (mode == RM_ZERO) begin
            AST_RTZ_NEVER_BUMPS: assert (!bump); // R6
        end
    end
endmodule

// File: rtl/rnd_incr.sv
// Module: rnd_incr
// Ripple incrementer: adds cin at bit 0 of a W-bit operand and exposes
// the carry-out as bit W of the sum. Assumes W >= 1.
module rnd_incr #(
    parameter int W = 30
) (
    input  logic [W-1:0] opnd,
    input  logic         cin,
    output logic [W:0]   sum
);
    logic [W:0] carry;

    assign carry[0] = cin;

    // Purpose: one half-adder cell per bit of the operand.
    for (genvar b = 0; b < W; b++) begin : g_cell
        assign sum[b]     = opnd[b] ^ carry[b];
        assign carry[b+1] = opnd[b] & carry[b];
    end

    assign sum[W] = carry[W];
endmodule

// File: rtl/mant_rounder.sv
// Module: mant_rounder (top)
// Drops guard and round bits, rounds the kept mantissa per the selected
// mode and registers the result with up/inexact flags. One cycle latency.
// Assumes MANT_W >= 4; the carry-out is kept and not renormalised.
module mant_rounder
    import rnd_pkg::*;
#(
    parameter int MANT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MANT_W-1:0] raw_mant,
    input  logic              raw_sticky,
    input  logic              val_neg,
    input  logic [1:0]        rnd_mode,
    output logic [MANT_W-2:0] res_mant,
    output logic              res_up,
    output logic              res_inexact
);
    localparam int KEEP_W = MANT_W - 2;
    localparam int OUT_W  = KEEP_W + 1;

    logic [KEEP_W-1:0] kept;
    logic              bump;
    logic              inexact;
    logic [OUT_W-1:0]  sum;
    rnd_mode_e         mode_e;

    // Purpose: shift out guard/round and cast the mode selector.
    always_comb begin
        kept   = raw_mant[MANT_W-1:2];
        mode_e = rnd_mode_e'(rnd_mode);
    end

    rnd_decide u_decide (
        .guard_bit  (raw_mant[1]),
        .round_bit  (raw_mant[0]),
        .sticky_bit (raw_sticky),
        .keep_lsb   (raw_mant[2]),
        .neg        (val_neg),
        .mode       (mode_e),
        .bump       (bump),
        .inexact    (inexact)
    );

    rnd_incr #(.W(KEEP_W)) u_incr (
        .opnd (kept),
        .cin  (bump),
        .sum  (sum)
    );

    // Purpose: output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mant    <= '0;
            res_up      <= 1'b0;
            res_inexact <= 1'b0;
        end else begin
            res_mant    <= sum;
            res_up      <= bump;
            res_inexact <= inexact;
        end
    end

    // Clocked checks on the registered outputs.
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (res_mant == '0 && !res_up && !res_inexact)); // R1
    AST_UP_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        res_up |-> res_inexact); // R3
    AST_INEXACT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_inexact == ($past(raw_mant[1:0]) != 2'b00 || $past(raw_sticky)))); // R4
    AST_NEAREST_GUARD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_mode == 2'b00 && !raw_mant[1]) |=> !res_up); // R5
    AST_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_mode == 2'b01) |=> !res_up); // R6
    AST_POSINF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_mode == 2'b10 && val_neg) |=> !res_up); // R7
    AST_NEGINF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_mode == 2'b11 && !val_neg) |=> !res_up); // R7
    AST_RESULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_mant ==
            ({1'b0, $past(raw_mant[MANT_W-1:2])} + OUT_W'(res_up)))); // R9
endmodule

// File: tb/test_mant_rounder.sv
module test_mant_rounder;
    localparam int MW = 32;
    localparam int OW = MW - 1;
    // entry: {mant[32], sticky, neg, mode[2], exp_mant[31], exp_up, exp_inx}
    localparam int EW = MW + 4 + OW + 2;
    localparam int NV = 14;
    localparam logic [EW-1:0] VECS [NV] = '{
        {32'h0000_0010, 1'b0, 1'b0, 2'b00, 31'h0000_0004, 1'b0, 1'b0},  // R3 exact
        {32'h0000_0016, 1'b0, 1'b0, 2'b00, 31'h0000_0006, 1'b1, 1'b1},  // R5 tie odd
        {32'h0000_0012, 1'b0, 1'b0, 2'b00, 31'h0000_0004, 1'b0, 1'b1},  // R5 tie even
        {32'h0000_0013, 1'b0, 1'b0, 2'b00, 31'h0000_0005, 1'b1, 1'b1},  // R5 above half
        {32'h0000_0011, 1'b0, 1'b0, 2'b00, 31'h0000_0004, 1'b0, 1'b1},  // R5 below half
        {32'h0000_0012, 1'b1, 1'b0, 2'b00, 31'h0000_0005, 1'b1, 1'b1},  // R5 sticky
        {32'h0000_0017, 1'b1, 1'b0, 2'b01, 31'h0000_0005, 1'b0, 1'b1},  // R6
        {32'h0000_0011, 1'b0, 1'b0, 2'b10, 31'h0000_0005, 1'b1, 1'b1},  // R7 +inf pos
        {32'h0000_0011, 1'b0, 1'b1, 2'b10, 31'h0000_0004, 1'b0, 1'b1},  // R7 +inf neg
        {32'h0000_0011, 1'b0, 1'b1, 2'b11, 31'h0000_0005, 1'b1, 1'b1},  // R7 -inf neg
        {32'h0000_0011, 1'b0, 1'b0, 2'b11, 31'h0000_0004, 1'b0, 1'b1},  // R7 -inf pos
        {32'hFFFF_FFFF, 1'b0, 1'b0, 2'b00, 31'h4000_0000, 1'b1, 1'b1},  // R8 carry
        {32'h0000_0000, 1'b1, 1'b0, 2'b10, 31'h0000_0001, 1'b1, 1'b1},  // R4 sticky only
        {32'h0000_0010, 1'b0, 1'b0, 2'b10, 31'h0000_0004, 1'b0, 1'b0}   // R3 directed exact
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] raw_mant = '0;
    logic          raw_sticky = 1'b0;
    logic          val_neg = 1'b0;
    logic [1:0]    rnd_mode = 2'b00;
    logic [OW-1:0] res_mant;
    logic          res_up;
    logic          res_inexact;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    mant_rounder #(.MANT_W(MW)) i_mant_rounder (
        .clk(clk), .rst_n(rst_n), .raw_mant(raw_mant), .raw_sticky(raw_sticky),
        .val_neg(val_neg), .rnd_mode(rnd_mode), .res_mant(res_mant),
        .res_up(res_up), .res_inexact(res_inexact)
    );

    // Reference model built from the requirements: {inexact, up, mant}
    function automatic logic [OW+1:0] ref_round(input logic [MW-1:0] m, input logic s,
                                                 input logic ng, input logic [1:0] md);
        logic lost;
        logic up;
        lost = m[1] | m[0] | s;
        case (md)
            2'b01:   up = 1'b0;
            2'b10:   up = lost & ~ng;
            2'b11:   up = lost & ng;
            default: up = m[1] & (m[0] | s | m[2]);
        endcase
        return {lost, up, ({1'b0, m[MW-1:2]} + OW'(up))};
    endfunction

    task automatic check(input string req, input logic [OW-1:0] em,
                         input logic eu, input logic ei);
        n_chk++;
        if (res_mant !== em || res_up !== eu || res_inexact !== ei) begin
            n_bad++;
            $display("FAIL %s actual mant=%h up=%b inx=%b expected mant=%h up=%b inx=%b",
                     req, res_mant, res_up, res_inexact, em, eu, ei);
        end
    endtask

    task automatic drive_and_check(input string req, input logic [MW-1:0] m, input logic s,
                                   input logic ng, input logic [1:0] md);
        logic [OW+1:0] r;
        @(negedge clk);
        raw_mant = m; raw_sticky = s; val_neg = ng; rnd_mode = md;
        r = ref_round(m, s, ng, md);
        @(negedge clk);
        check(req, r[OW-1:0], r[OW], r[OW+1]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset clears outputs even with nonzero inputs
        raw_mant = 32'hFFFF_FFFF; raw_sticky = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {raw_mant, raw_sticky, val_neg, rnd_mode} = VECS[k][EW-1 -: MW+4];
            @(negedge clk);
            check($sformatf("R3-R8 vec%0d", k), VECS[k][OW+1:2], VECS[k][1], VECS[k][0]);
        end

        // R2: output holds until the next edge, then updates
        @(negedge clk);
        raw_mant = 32'h0000_0013; raw_sticky = 1'b0; val_neg = 1'b0; rnd_mode = 2'b00;
        @(negedge clk);
        raw_mant = 32'h0000_0020; rnd_mode = 2'b01;
        #1;
        check("R2 hold", 31'h5, 1'b1, 1'b1);
        @(negedge clk);
        check("R2 update", 31'h8, 1'b0, 1'b0);

        // R1: reset mid-run clears again
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid", '0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R8: carry into top bit in directed mode
        drive_and_check("R8", 32'hFFFF_FFFC, 1'b1, 1'b1, 2'b11);

        // R5: random ties (guard set, round and sticky clear) in nearest mode
        for (int k = 0; k < 200; k++) begin
            logic [MW-1:0] m;
            m = $urandom;
            m[1:0] = 2'b10;
            drive_and_check("R5 tie", m, 1'b0, k[0], 2'b00);
        end

        // R4 R6 R7 R9: random inputs, all modes
        for (int k = 0; k < 2000; k++) begin
            logic [MW-1:0] m;
            logic [3:0]    ctl;
            m = $urandom;
            ctl = 4'($urandom);
            drive_and_check("R9 rand", m, ctl[0], ctl[1], ctl[3:2]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule